// File: doc/BRIEF.md
# Multi-Mode Period Timer Counter

This block is a free-standing timer counter driven by a single-cycle count enable that marks each timer-clock tick. A two-bit mode input picks one of four behaviours: halted, counting up to a programmable period and restarting, counting freely up to a maximum picked by a length-select input, or sweeping up to the period and back down to zero. The period lives in a latch written through a strobe. Writes take effect at once, and the counter reacts safely when the new period lies below the current count.

Two sticky flags report events. The top flag marks the count arriving at the period value. The wrap flag marks the count returning to zero. Each flag stays set until its own clear strobe pulses. A new event in the same cycle as a clear leaves the flag set.

Top module: `mode_timer`

## Requirements
- R1: Mode encoding on `mode_i`: 2'b00 halt, 2'b01 up, 2'b10 continuous, 2'b11 up/down. While halted the count holds its value even when `tick_i` is high.
- R2: In up mode each tick adds one while count < period. A tick with count == period returns the count to 0, so one period spans period+1 ticks.
- R3: In up mode, a tick with the count above the period returns the count to 0 and sets the wrap flag.
- R4: In continuous mode the count climbs to a maximum chosen by `len_sel_i` (2'b00 = 65535, 2'b01 = 4095, 2'b10 = 1023, 2'b11 = 255). On the next tick it rolls to 0.
- R5: In up/down mode the count runs 0,1,…,period,period-1,…,1,0 and repeats. The direction always starts upward after entering this mode.
- R6: The top flag is set on the tick that brings the count to the period value, in up and up/down modes only. Continuous mode never sets it.
- R7: The wrap flag is set on the tick where the count goes to 0. This covers the roll from the period in up mode, the roll from the length maximum in continuous mode, and the step from 1 to 0 in up/down mode.
- R8: Each flag stays set until its own clear strobe (`clr_top_i`, `clr_wrap_i`) pulses. A clear aimed at one flag leaves the other unchanged. A set and a clear in the same cycle leave the flag set.
- R9: The count changes only in cycles where `tick_i` is high.
- R10: A period write that is not below the current count takes effect immediately. The counter then runs up to the new period and sets the top flag there.
- R11: A period write below the current count makes the count roll to 0 on the next up-mode tick.
- R12: Reset (`rst_ni` low) clears the count, both flags and the period to 0. With period 0, an up-mode tick keeps the count at 0 and sets the wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one timer-clock tick |
| mode_i | input | 2 | Counting mode select |
| len_sel_i | input | 2 | Continuous-mode length select |
| period_i | input | 16 | New period value |
| period_we_i | input | 1 | Period write strobe |
| clr_top_i | input | 1 | Clear strobe for the top flag |
| clr_wrap_i | input | 1 | Clear strobe for the wrap flag |
| count_o | output | 16 | Current count |
| top_flag_o | output | 1 | Sticky period-reached flag |
| wrap_flag_o | output | 1 | Sticky wrap-to-zero flag |

## Verification
The bench builds the block with its default 16-bit counter and the default length table (16, 12, 10 and 8 bits). With ticks every cycle, every continuous-mode maximum, including the full 65535 roll, is reached within a short run. The small period of 3 used by the vector table exposes the up-mode and up/down turning points and the flag timing within a few cycles. Directed steps then raise and lower the period mid-count.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } mt_mode_e;
endpackage

// File: rtl/mt_period_reg.sv
`timescale 1ns/1ps
module mt_period_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] period_o
);
  // immediate load: new value is live on the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   period_o <= '0;
    else if (we_i) period_o <= din_i;
  end

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> period_o == $past(din_i));
endmodule

// File: rtl/mt_sticky_flag.sv
`timescale 1ns/1ps
module mt_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/mt_count_core.sv
`timescale 1ns/1ps
module mt_count_core
  import mt_pkg::*;
#(
  parameter int W      = 16,
  parameter int LEN0_B = 16,
  parameter int LEN1_B = 12,
  parameter int LEN2_B = 10,
  parameter int LEN3_B = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   len_sel_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         top_evt_o,
  output logic         wrap_evt_o
);
  localparam int NLEN = 4;

  mt_mode_e     mode;
  logic [W-1:0] cnt_q, cnt_d, inc, dec, lim;
  logic         dn_q, dn_d, go_down;
  logic [W-1:0] lim_tab [NLEN];

  assign mode = mt_mode_e'(mode_i);

  for (genvar g = 0; g < NLEN; g++) begin : g_lim
    localparam int BITS = (g == 0) ? LEN0_B : (g == 1) ? LEN1_B :
                          (g == 2) ? LEN2_B : LEN3_B;
    localparam int EFF  = (BITS > W) ? W : BITS;
    assign lim_tab[g] = W'((64'd1 << EFF) - 64'd1);
  end

  assign lim     = lim_tab[len_sel_i];
  assign inc     = cnt_q + 1'b1;
  assign dec     = cnt_q - 1'b1;
  // above the period while rising counts as the falling phase
  assign go_down = dn_q | (cnt_q >= period_i);

  always_comb begin
    cnt_d      = cnt_q;
    dn_d       = (mode == MODE_UPDN) ? dn_q : 1'b0;
    top_evt_o  = 1'b0;
    wrap_evt_o = 1'b0;
    if (tick_i) begin
      unique case (mode)
        MODE_STOP: ;
        MODE_UP: begin
          if (cnt_q >= period_i) begin
            cnt_d      = '0;
            wrap_evt_o = 1'b1;
          end else begin
            cnt_d     = inc;
            top_evt_o = (inc == period_i);
          end
        end
        MODE_CONT: begin
          if (cnt_q >= lim) begin
            cnt_d      = '0;
            wrap_evt_o = 1'b1;
          end else begin
            cnt_d = inc;
          end
        end
        MODE_UPDN: begin
          if (!go_down) begin
            cnt_d = inc;
            if (inc == period_i) begin
              top_evt_o = 1'b1;
              dn_d      = 1'b1;
            end
          end else if (cnt_q == '0) begin
            dn_d = 1'b0;
          end else begin
            cnt_d = dec;
            dn_d  = (cnt_q != W'(1));
            wrap_evt_o = (cnt_q == W'(1));
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign count_o = cnt_q;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_STOP) |=> $stable(cnt_q));
  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_up_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode == MODE_UP && cnt_q < period_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_up_roll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode == MODE_UP && cnt_q >= period_i) |=> cnt_q == '0);
  p_cont_roll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode == MODE_CONT && cnt_q == lim) |=> cnt_q == '0);
  p_updn_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode == MODE_UPDN && cnt_q != '0) |=>
      (cnt_q == W'($past(cnt_q) + 1'b1) || cnt_q == W'($past(cnt_q) - 1'b1)));
  p_top_cont_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_CONT) |-> !top_evt_o);
  p_wrap_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt_o |=> cnt_q == '0);
endmodule

// File: rtl/mode_timer.sv
`timescale 1ns/1ps
module mode_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   len_sel_i,
  input  logic [W-1:0] period_i,
  input  logic         period_we_i,
  input  logic         clr_top_i,
  input  logic         clr_wrap_i,
  output logic [W-1:0] count_o,
  output logic         top_flag_o,
  output logic         wrap_flag_o
);
  localparam int NFLAG = 2;

  logic [W-1:0]     period_q;
  logic [NFLAG-1:0] evt, clr, flag;

  mt_period_reg #(.W(W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (period_we_i),
    .din_i    (period_i),
    .period_o (period_q)
  );

  mt_count_core #(.W(W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .len_sel_i  (len_sel_i),
    .period_i   (period_q),
    .count_o    (count_o),
    .top_evt_o  (evt[0]),
    .wrap_evt_o (evt[1])
  );

  assign clr = {clr_wrap_i, clr_top_i};

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    mt_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[f]),
      .clr_i  (clr[f]),
      .flag_o (flag[f])
    );
  end

  assign top_flag_o  = flag[0];
  assign wrap_flag_o = flag[1];

  p_top_at_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(top_flag_o) && !$past(period_we_i)) |-> count_o == period_q);
endmodule

// File: tb/mode_timer_tb_top.sv
`timescale 1ns/1ps
module mode_timer_tb_top;
  localparam int W = 16;
  localparam int NV = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [1:0]   len_sel_i = 2'b00;
  logic [W-1:0] period_i = '0;
  logic         period_we_i = 1'b0;
  logic         clr_top_i = 1'b0;
  logic         clr_wrap_i = 1'b0;
  logic [W-1:0] count_o;
  logic         top_flag_o, wrap_flag_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  mode_timer #(.W(W)) dut_i (.*);

  // {mode, tick, clr_top, clr_wrap, exp_count, exp_top, exp_wrap}, period = 3, len 16-bit
  localparam logic [22:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 1'b0},  // R2
    {2'b01, 1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0},  // R2
    {2'b01, 1'b1, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0},  // R6
    {2'b01, 1'b0, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0},  // R9
    {2'b01, 1'b1, 1'b0, 1'b0, 16'd0, 1'b1, 1'b1},  // R7
    {2'b00, 1'b1, 1'b1, 1'b1, 16'd0, 1'b0, 1'b0},  // R1 R8
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 1'b0},  // R5
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0},  // R5
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0},  // R6
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 1'b0},  // R5
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 1'b0},  // R5
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd0, 1'b1, 1'b1},  // R7
    {2'b11, 1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 1'b1},  // R5
    {2'b10, 1'b1, 1'b1, 1'b1, 16'd2, 1'b0, 1'b0}   // R4 R8
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [W-1:0] c, input logic t, input logic w);
    chk(req, "count", 32'(count_o), 32'(c));
    chk(req, "top",   32'(top_flag_o), 32'(t));
    chk(req, "wrap",  32'(wrap_flag_o), 32'(w));
  endtask

  // one clock with the given strobes; outputs sampled 1 ns after the edge
  task automatic step(input logic tk, input logic ct, input logic cw);
    @(negedge clk_i);
    tick_i = tk; clr_top_i = ct; clr_wrap_i = cw;
    @(posedge clk_i); #1;
    tick_i = 1'b0; clr_top_i = 1'b0; clr_wrap_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [1:0] l);
    @(negedge clk_i);
    mode_i = m; len_sel_i = l;
  endtask

  task automatic wr_period(input logic [W-1:0] v);
    @(negedge clk_i);
    period_i = v; period_we_i = 1'b1;
    @(posedge clk_i); #1;
    period_we_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_900_000;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_all("R12", 16'd0, 1'b0, 1'b0);

    // vector table
    wr_period(16'd3);
    for (int v = 0; v < NV; v++) begin
      set_mode(VEC[v][22:21], 2'b00);
      step(VEC[v][20], VEC[v][19], VEC[v][18]);
      chk_all($sformatf("vec%0d R1/R2/R5/R6/R7/R8/R9", v), VEC[v][17:2], VEC[v][1], VEC[v][0]);
    end

    // R12: reset mid-run clears count, flags and period
    do_reset();
    chk_all("R12", 16'd0, 1'b0, 1'b0);
    set_mode(2'b01, 2'b00);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R12 period zero", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    // R4: continuous maxima; R6: no top flag in continuous mode
    wr_period(16'd5);
    set_mode(2'b10, 2'b11);
    ticks(255);
    chk_all("R4 8-bit max R6", 16'd255, 1'b0, 1'b0);
    ticks(1);
    chk_all("R4 8-bit roll R7", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    set_mode(2'b10, 2'b10);
    ticks(1023);
    chk_all("R4 10-bit max", 16'd1023, 1'b0, 1'b0);
    ticks(1);
    chk_all("R4 10-bit roll", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    set_mode(2'b10, 2'b01);
    ticks(4095);
    chk_all("R4 12-bit max", 16'd4095, 1'b0, 1'b0);
    ticks(1);
    chk_all("R4 12-bit roll", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    set_mode(2'b10, 2'b00);
    ticks(65535);
    chk_all("R4 16-bit max", 16'd65535, 1'b0, 1'b0);
    ticks(1);
    chk_all("R4 16-bit roll", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    // R3: enter up mode above the period
    set_mode(2'b10, 2'b11);
    ticks(10);
    chk("R3", "count", 32'(count_o), 32'd10);
    set_mode(2'b01, 2'b11);
    ticks(1);
    chk_all("R3 restart", 16'd0, 1'b0, 1'b1);
    ticks(5);
    chk_all("R3 then R6", 16'd5, 1'b1, 1'b1);
    ticks(1);
    step(1'b0, 1'b1, 1'b1);
    chk_all("R8 clear both", 16'd0, 1'b0, 1'b0);

    // R10: raise the period mid-count
    ticks(2);
    wr_period(16'd8);
    ticks(5);
    chk_all("R10 past old period", 16'd7, 1'b0, 1'b0);
    ticks(1);
    chk_all("R10 reach new period", 16'd8, 1'b1, 1'b0);
    ticks(1);
    chk_all("R10 roll", 16'd0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);

    // R11: lower the period below the count
    ticks(6);
    wr_period(16'd3);
    chk("R11 write no move", "count", 32'(count_o), 32'd6);
    ticks(1);
    chk_all("R11 roll", 16'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    // R8: set beats clear; clears are per flag
    ticks(2);
    step(1'b1, 1'b1, 1'b0);
    chk_all("R8 set wins", 16'd3, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    chk_all("R8 clear top", 16'd3, 1'b0, 1'b0);
    ticks(1);
    step(1'b0, 1'b1, 1'b0);
    chk_all("R8 wrap kept", 16'd0, 1'b0, 1'b1);

    // R1: halt with ticks
    set_mode(2'b00, 2'b00);
    ticks(3);
    chk("R1 halt", "count", 32'(count_o), 32'd0);

    finish_run();
  end
endmodule